// File: doc/BRIEF.md
# Match/Capture Timer Counter

A 32-bit count register advances either on a prescaled core clock or on the edges of one of four external count inputs. Four compare channels watch the count. On a hit, each channel can raise an interrupt flag, send the count back to zero, stop the counter, and drive its own external output low, high or to the opposite level. Four capture channels copy the count when their input shows an enabled edge. All external inputs pass through a two-flop synchronizer before edge detection.

Software programs and observes the block through a word-addressed synchronous register port. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Interrupt flags are sticky and clear when a 1 is written to them. The single interrupt line is the OR of the flags whose source has its interrupt enable set.

Top module: `mctimer`

## Requirements
- R1: After reset every register reads 0, `match_out` is 0 and `irq` is 0.
- R2: The word addresses are: flags 0, control 1, count 2, prescale limit 3, prescale count 4, compare control 5, compare values 6..9, capture control 10, capture values 11..14, output control 15, source select 28. Writes read back the written value; unused high bits read 0.
- R3: With control bit 0 (run) set, bit 1 (hold) clear and source mode 0, the prescale count rises by one per clock and wraps to 0 on the clock where it equals the limit. On that wrap clock the count advances, so after k clocks the count is k/(limit+1) and the prescale count is k mod (limit+1).
- R4: While hold is set, the count and prescale count stay at 0. While run is clear, the count does not change except by a software write.
- R5: A hit occurs on an advance clock where count equals compare value n. Every hit sets flag bit n. If compare control bit 3n+1 is set, the count goes to 0 instead of advancing.
- R6: If compare control bit 3n+2 is set, a hit on channel n clears run, and the count keeps the hit value.
- R7: Output control bit n is the state of `match_out[n]`. Its action field at bits 2n+5:2n+4 selects what a hit does: 0 nothing, 1 drive low, 2 drive high, 3 toggle.
- R8: Capture control bit 3n selects the rising edge and bit 3n+1 the falling edge of `cap_in[n]`. An enabled edge copies the count into capture value n and sets flag bit 4+n. The copied value is the count two clocks after the input changes. An edge of a disabled polarity changes nothing.
- R9: Source select bits [1:0] set the mode: 1 counts rising edges, 2 counts falling edges, 3 counts both edges of `cnt_in[sel]`, where sel is bits [3:2]. The other count inputs are ignored.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it. A new event wins over a clear. `irq` is the OR of the flags whose enable is set: compare control bit 3n for flag n, and capture control bit 3n+2 for flag 4+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cnt_in | input | 4 | External count inputs |
| cap_in | input | 4 | Capture inputs |
| match_out | output | 4 | External compare outputs |
| irq | output | 1 | Combined interrupt |

## Verification
Timer mode is tried with random prescale limits and run lengths. This separates a wrap on equality from an off-by-one in either counter. Compare reset is tried with random compare values on top of random prescaling, which tells a reset-to-zero apart from a plain increment at the hit. Stop, set, clear and toggle actions each get a directed run. Capture and external counting are driven with pulses on the selected input while a neighbouring input toggles, so a wrong edge polarity, a wrong input select or a missing synchronizer stage each shows as a distinct value.

// File: rtl/mctimer_pkg.sv
package mctimer_pkg;
  localparam int ADDR_W = 5;
  localparam int BUS_W  = 32;
  localparam int NCH    = 4;
  localparam int NIN    = 4;
  localparam int SEL_W  = $clog2(NIN);
  localparam int FLAG_W = 2 * NCH;
  localparam int CTL_W  = 3 * NCH;
  localparam int ACT_W  = 2 * NCH;

  localparam logic [ADDR_W-1:0] A_FLAG  = 5'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 5'd2;
  localparam logic [ADDR_W-1:0] A_PLIM  = 5'd3;
  localparam logic [ADDR_W-1:0] A_PCNT  = 5'd4;
  localparam logic [ADDR_W-1:0] A_MCTL  = 5'd5;
  localparam logic [ADDR_W-1:0] A_MVAL0 = 5'd6;
  localparam logic [ADDR_W-1:0] A_CCTL  = 5'd10;
  localparam logic [ADDR_W-1:0] A_CVAL0 = 5'd11;
  localparam logic [ADDR_W-1:0] A_EXT   = 5'd15;
  localparam logic [ADDR_W-1:0] A_SRC   = 5'd28;

  typedef enum logic [1:0] {
    SRC_CLOCK = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_BOTH  = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    EXT_KEEP = 2'd0,
    EXT_LOW  = 2'd1,
    EXT_HIGH = 2'd2,
    EXT_FLIP = 2'd3
  } ext_act_e;

  function automatic logic ext_next(input ext_act_e act, input logic cur);
    case (act)
      EXT_LOW:  return 1'b0;
      EXT_HIGH: return 1'b1;
      EXT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/mctimer_edge.sv
module mctimer_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;
    logic              last_q, last_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[i]};
      last_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        last_q  <= last_d;
      end
    end

    assign rise[i] = chain_q[STAGES-1] & ~last_q;
    assign fall[i] = ~chain_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/mctimer_tick.sv
module mctimer_tick
  import mctimer_pkg::*;
#(
  parameter int CW  = 32,
  parameter int NI  = 4,
  parameter int SW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  src_mode_e     mode,
  input  logic [SW-1:0] sel,
  input  logic [NI-1:0] ev_rise,
  input  logic [NI-1:0] ev_fall,
  input  logic [CW-1:0] limit,
  input  logic          pcnt_wr,
  input  logic [CW-1:0] pcnt_wdata,
  output logic [CW-1:0] pcnt,
  output logic          tick
);
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic          ext_ev, wrap;

  always_comb begin
    case (mode)
      SRC_RISE: ext_ev = ev_rise[sel];
      SRC_FALL: ext_ev = ev_fall[sel];
      SRC_BOTH: ext_ev = ev_rise[sel] | ev_fall[sel];
      default:  ext_ev = 1'b0;
    endcase
    wrap = (pcnt_q == limit);
    tick = run & ~hold & ((mode == SRC_CLOCK) ? wrap : ext_ev);

    pcnt_d = pcnt_q;
    if (hold) begin
      pcnt_d = '0;
    end else if (pcnt_wr) begin
      pcnt_d = pcnt_wdata;
    end else if (run && mode == SRC_CLOCK) begin
      pcnt_d = wrap ? '0 : pcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign pcnt = pcnt_q;
endmodule

// File: rtl/mctimer_match.sv
module mctimer_match
  import mctimer_pkg::*;
#(
  parameter int CW = 32,
  parameter int NC = 4
) (
  input  logic                  tick,
  input  logic [CW-1:0]         count,
  input  logic [NC-1:0][CW-1:0] mval,
  input  logic [3*NC-1:0]       mctl,
  input  logic [NC-1:0]         ext_cur,
  input  logic [2*NC-1:0]       act,
  output logic [NC-1:0]         hit,
  output logic                  any_reset,
  output logic                  any_stop,
  output logic [NC-1:0]         ext_hw
);
  logic [NC-1:0] rst_v, stop_v;

  for (genvar n = 0; n < NC; n++) begin : g_ch
    assign hit[n]    = tick & (count == mval[n]);
    assign rst_v[n]  = hit[n] & mctl[3*n+1];
    assign stop_v[n] = hit[n] & mctl[3*n+2];
    assign ext_hw[n] = hit[n] ? ext_next(ext_act_e'(act[2*n+1 -: 2]), ext_cur[n])
                              : ext_cur[n];
  end

  assign any_reset = |rst_v;
  assign any_stop  = |stop_v;
endmodule

// File: rtl/mctimer_capture.sv
module mctimer_capture #(
  parameter int CW = 32,
  parameter int NC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*NC-1:0]       cctl,
  input  logic [NC-1:0]         rise,
  input  logic [NC-1:0]         fall,
  input  logic [CW-1:0]         count,
  output logic [NC-1:0][CW-1:0] cval,
  output logic [NC-1:0]         cap_ev
);
  for (genvar n = 0; n < NC; n++) begin : g_ch
    logic [CW-1:0] val_q, val_d;

    always_comb begin
      cap_ev[n] = (rise[n] & cctl[3*n]) | (fall[n] & cctl[3*n+1]);
      val_d     = cap_ev[n] ? count : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign cval[n] = val_q;
  end
endmodule

// File: rtl/mctimer.sv
module mctimer
  import mctimer_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NIN-1:0]    cnt_in,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    match_out,
  output logic              irq
);
  logic [1:0]                rs_q;
  logic                      rst_n_sync;
  logic                      run_q, run_d, hold_q, hold_d;
  logic [CW-1:0]             count_q, count_d, plim_q, plim_d, pcnt;
  logic [CTL_W-1:0]          mctl_q, mctl_d, cctl_q, cctl_d;
  logic [NCH-1:0][CW-1:0]    mval_q, mval_d, cval;
  logic [NCH-1:0]            ext_q, ext_d, ext_hw;
  logic [ACT_W-1:0]          act_q, act_d;
  logic [1:0]                mode_q, mode_d;
  logic [SEL_W-1:0]          sel_q, sel_d;
  logic [FLAG_W-1:0]         flag_q, flag_d, flag_clr, irq_en;
  logic [NIN-1:0]            cnt_rise, cnt_fall;
  logic [NCH-1:0]            cap_rise, cap_fall, cap_ev, hit;
  logic                      tick, any_reset, any_stop;

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_sync = rs_q[1];

  mctimer_edge #(.W(NIN), .STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst_n(rst_n_sync), .din(cnt_in), .rise(cnt_rise), .fall(cnt_fall)
  );

  mctimer_edge #(.W(NCH), .STAGES(SYNC_STAGES)) u_cap_edge (
    .clk(clk), .rst_n(rst_n_sync), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
  );

  mctimer_tick #(.CW(CW), .NI(NIN), .SW(SEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n_sync), .run(run_q), .hold(hold_q),
    .mode(src_mode_e'(mode_q)), .sel(sel_q), .ev_rise(cnt_rise), .ev_fall(cnt_fall),
    .limit(plim_q), .pcnt_wr(wr_at(A_PCNT)), .pcnt_wdata(bus_wdata[CW-1:0]),
    .pcnt(pcnt), .tick(tick)
  );

  mctimer_match #(.CW(CW), .NC(NCH)) u_match (
    .tick(tick), .count(count_q), .mval(mval_q), .mctl(mctl_q),
    .ext_cur(ext_q), .act(act_q), .hit(hit), .any_reset(any_reset),
    .any_stop(any_stop), .ext_hw(ext_hw)
  );

  mctimer_capture #(.CW(CW), .NC(NCH)) u_cap (
    .clk(clk), .rst_n(rst_n_sync), .cctl(cctl_q), .rise(cap_rise),
    .fall(cap_fall), .count(count_q), .cval(cval), .cap_ev(cap_ev)
  );

  // Next-state logic for the register file
  always_comb begin
    run_d  = wr_at(A_CTRL) ? bus_wdata[0] : (run_q & ~any_stop);
    hold_d = wr_at(A_CTRL) ? bus_wdata[1] : hold_q;

    count_d = count_q;
    if (hold_q) begin
      count_d = '0;
    end else if (wr_at(A_COUNT)) begin
      count_d = bus_wdata[CW-1:0];
    end else if (tick) begin
      if (any_reset)      count_d = '0;
      else if (!any_stop) count_d = count_q + CW'(1);
    end

    plim_d = wr_at(A_PLIM) ? bus_wdata[CW-1:0] : plim_q;
    mctl_d = wr_at(A_MCTL) ? bus_wdata[CTL_W-1:0] : mctl_q;
    cctl_d = wr_at(A_CCTL) ? bus_wdata[CTL_W-1:0] : cctl_q;
    for (int n = 0; n < NCH; n++) begin
      mval_d[n] = wr_at(A_MVAL0 + ADDR_W'(n)) ? bus_wdata[CW-1:0] : mval_q[n];
    end

    ext_d  = wr_at(A_EXT) ? bus_wdata[NCH-1:0] : ext_hw;
    act_d  = wr_at(A_EXT) ? bus_wdata[NCH+ACT_W-1:NCH] : act_q;
    mode_d = wr_at(A_SRC) ? bus_wdata[1:0] : mode_q;
    sel_d  = wr_at(A_SRC) ? bus_wdata[2+SEL_W-1:2] : sel_q;

    flag_clr = wr_at(A_FLAG) ? bus_wdata[FLAG_W-1:0] : '0;
    flag_d   = (flag_q & ~flag_clr) | {cap_ev, hit};
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      count_q <= '0;
      plim_q  <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      mval_q  <= '0;
      ext_q   <= '0;
      act_q   <= '0;
      mode_q  <= '0;
      sel_q   <= '0;
      flag_q  <= '0;
    end else begin
      run_q   <= run_d;
      hold_q  <= hold_d;
      count_q <= count_d;
      plim_q  <= plim_d;
      mctl_q  <= mctl_d;
      cctl_q  <= cctl_d;
      mval_q  <= mval_d;
      ext_q   <= ext_d;
      act_q   <= act_d;
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      flag_q  <= flag_d;
    end
  end

  // Interrupt enable mask lined up with the flag bits
  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      irq_en[n]     = mctl_q[3*n];
      irq_en[NCH+n] = cctl_q[3*n+2];
    end
  end
  assign irq       = |(flag_q & irq_en);
  assign match_out = ext_q;

  // Read path
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAG:  bus_rdata = BUS_W'(flag_q);
      A_CTRL:  bus_rdata = BUS_W'({hold_q, run_q});
      A_COUNT: bus_rdata = BUS_W'(count_q);
      A_PLIM:  bus_rdata = BUS_W'(plim_q);
      A_PCNT:  bus_rdata = BUS_W'(pcnt);
      A_MCTL:  bus_rdata = BUS_W'(mctl_q);
      A_CCTL:  bus_rdata = BUS_W'(cctl_q);
      A_EXT:   bus_rdata = BUS_W'({act_q, ext_q});
      A_SRC:   bus_rdata = BUS_W'({sel_q, mode_q});
      default: bus_rdata = '0;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == A_MVAL0 + ADDR_W'(n)) bus_rdata = BUS_W'(mval_q[n]);
      if (bus_addr == A_CVAL0 + ADDR_W'(n)) bus_rdata = BUS_W'(cval[n]);
    end
  end
endmodule

// File: rtl/mctimer_chk.sv
module mctimer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          run,
  input logic          hold,
  input logic          tick,
  input logic [CW-1:0] count,
  input logic [CW-1:0] pcnt,
  input logic [7:0]    flags,
  input logic          irq,
  input logic [3:0]    match_out
);
  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0 && pcnt == '0));

  assert_idle_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && !bus_wr) |=> $stable(count));

  assert_ext_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_wr) |=> $stable(match_out));

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));
endmodule

bind mctimer mctimer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .bus_wr(bus_wr), .run(run_q), .hold(hold_q),
  .tick(tick), .count(count_q), .pcnt(pcnt), .flags(flag_q), .irq(irq),
  .match_out(match_out)
);

// File: tb/mctimer_bench.sv
`timescale 1ns/1ps
module mctimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cnt_in = '0;
  logic [3:0]  cap_in = '0;
  logic [3:0]  mout;
  logic        irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mctimer u_mctimer (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .cnt_in(cnt_in), .cap_in(cap_in), .match_out(mout), .irq(irq)
  );

  function automatic int exp_count(int k, int p);
    return k / (p + 1);
  endfunction
  function automatic int exp_pcnt(int k, int p);
    return k % (p + 1);
  endfunction
  function automatic int exp_wrapped(int k, int p, int m);
    return exp_count(k, p) % (m + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5;
    d = rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic pulses(input int idx, input int num, input int other);
    for (int i = 0; i < num; i++) begin
      cnt_in[idx] = 1'b1; cnt_in[other] = ~cnt_in[other];
      edges(3);
      cnt_in[idx] = 1'b0; cnt_in[other] = ~cnt_in[other];
      edges(3);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c;
    int p, m, k, s;
    int unsigned seed_set;
    seed_set = $urandom(32'h5eed);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    edges(4);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rreg(5'(a), d); chk("R1 reg", d, 0);
    end
    rreg(5'd28, d); chk("R1 src", d, 0);
    chk("R1 match_out", 32'(mout), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 readback
    d = $urandom; wreg(5'd3, d); rreg(5'd3, c); chk("R2 plim", c, d);
    d = $urandom; wreg(5'd8, d); rreg(5'd8, c); chk("R2 mval2", c, d);
    wreg(5'd5, 32'hFFFF_FFFF); rreg(5'd5, c); chk("R2 mctl width", c, 32'h0FFF);
    wreg(5'd15, 32'hFFFF_F0F0); rreg(5'd15, c); chk("R2 ext width", c, 32'h0F0);
    wreg(5'd28, 32'h0000_00FB); rreg(5'd28, c); chk("R2 src width", c, 32'h0B);
    wreg(5'd5, 0); wreg(5'd15, 0); wreg(5'd28, 0); wreg(5'd8, 0);

    // R4 hold keeps counters at zero
    wreg(5'd3, 0); wreg(5'd1, 3); edges(6);
    rreg(5'd2, d); chk("R4 hold count", d, 0);
    rreg(5'd4, d); chk("R4 hold pcnt", d, 0);

    // R3 random prescale runs
    for (int it = 0; it < 10; it++) begin
      p = $urandom_range(0, 4); k = $urandom_range(0, 60);
      wreg(5'd1, 2); wreg(5'd3, 32'(p)); wreg(5'd1, 1);
      edges(k);
      rreg(5'd2, d); chk("R3 count", d, 32'(exp_count(k, p)));
      rreg(5'd4, d); chk("R3 pcnt", d, 32'(exp_pcnt(k, p)));
    end
    wreg(5'd1, 0); rreg(5'd2, c); edges(5);
    rreg(5'd2, d); chk("R4 frozen when run clear", d, c);

    // R5 random compare-reset runs on channel 0 with interrupt enable
    for (int it = 0; it < 8; it++) begin
      p = $urandom_range(0, 2); m = $urandom_range(1, 6); k = $urandom_range(1, 50);
      wreg(5'd1, 2); wreg(5'd3, 32'(p)); wreg(5'd6, 32'(m));
      wreg(5'd5, 32'h3); wreg(5'd0, 32'hFF); wreg(5'd1, 1);
      edges(k);
      rreg(5'd2, d); chk("R5 wrapped count", d, 32'(exp_wrapped(k, p, m)));
      rreg(5'd0, d);
      chk("R5 flag0", 32'(d[0]), 32'(exp_count(k, p) >= m + 1));
      chk("R10 irq follows flag0", 32'(irq), 32'(exp_count(k, p) >= m + 1));
    end

    // R6 stop on channel 1
    s = 7;
    wreg(5'd1, 2); wreg(5'd3, 0); wreg(5'd5, 32'h20); wreg(5'd7, 32'(s));
    wreg(5'd0, 32'hFF); wreg(5'd1, 1);
    edges(s + 6);
    rreg(5'd2, d); chk("R6 stopped count", d, 32'(s));
    rreg(5'd1, d); chk("R6 run cleared", d, 0);
    rreg(5'd0, d); chk("R5 flag1 set", 32'(d[1]), 1);
    chk("R10 irq masked", 32'(irq), 0);

    // R10 clear semantics
    wreg(5'd5, 32'h8);
    chk("R10 irq enabled", 32'(irq), 1);
    wreg(5'd0, 32'h0); rreg(5'd0, d); chk("R10 write zero keeps", 32'(d[1]), 1);
    wreg(5'd0, 32'h2); rreg(5'd0, d); chk("R10 write one clears", 32'(d[1]), 0);
    chk("R10 irq dropped", 32'(irq), 0);

    // R7 toggle with reset on channel 2
    for (int it = 0; it < 5; it++) begin
      m = $urandom_range(1, 6); k = $urandom_range(0, 40);
      wreg(5'd1, 2); wreg(5'd3, 0); wreg(5'd8, 32'(m));
      wreg(5'd5, 32'h80); wreg(5'd15, 32'h300); wreg(5'd1, 1);
      edges(k);
      chk("R7 toggle", 32'(mout[2]), 32'((k / (m + 1)) % 2));
      rreg(5'd15, d); chk("R7 state bit", 32'(d[2]), 32'(mout[2]));
    end

    // R7 set on channel 0, clear on channel 3
    wreg(5'd1, 2); wreg(5'd5, 0); wreg(5'd6, 3); wreg(5'd9, 0);
    wreg(5'd15, 32'h428);
    chk("R7 before hits", 32'(mout), 32'h8);
    wreg(5'd1, 1); edges(8);
    chk("R7 set and clear", 32'(mout), 32'h1);

    // R8 capture
    wreg(5'd1, 2); wreg(5'd15, 0); wreg(5'd0, 32'hFF);
    wreg(5'd10, 32'h15); wreg(5'd1, 1);
    edges(7);
    rreg(5'd2, c); cap_in[0] = 1'b1; edges(5);
    rreg(5'd11, d); chk("R8 rising capture", d, c + 2);
    rreg(5'd0, d); chk("R8 flag4", 32'(d[4]), 1);
    chk("R10 irq capture", 32'(irq), 1);
    cap_in[1] = 1'b1; edges(5);
    rreg(5'd12, d); chk("R8 rising ignored", d, 0);
    rreg(5'd0, d); chk("R8 flag5 untouched", 32'(d[5]), 0);
    rreg(5'd2, c); cap_in[1] = 1'b0; edges(5);
    rreg(5'd12, d); chk("R8 falling capture", d, c + 2);
    cap_in = '0; wreg(5'd10, 0); wreg(5'd0, 32'hFF); edges(5);

    // R9 external counting modes
    wreg(5'd1, 2); wreg(5'd28, 32'h9); wreg(5'd1, 1);
    pulses(2, 5, 0); edges(5);
    rreg(5'd2, d); chk("R9 rising sel2", d, 5);
    wreg(5'd1, 2); wreg(5'd28, 32'hB); wreg(5'd1, 1);
    pulses(2, 4, 3); edges(5);
    rreg(5'd2, d); chk("R9 both sel2", d, 8);
    wreg(5'd1, 2); wreg(5'd28, 32'h6); wreg(5'd1, 1);
    pulses(1, 3, 2); edges(5);
    rreg(5'd2, d); chk("R9 falling sel1", d, 3);
    rreg(5'd4, d); chk("R9 prescaler idle", d, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule